// File: doc/BRIEF.md
# Token-Pulse Program Sequencer

This block carries out one fixed, short program in hardware. Control does not live in an encoded state register. A single-cycle token pulse moves through small control cells, one cell per program construct. The program has three parts, run in order:

1. An assignment: `acc := seed_i` and, in the same step, `mode := mode_i`.
2. A loop: `while (acc > floor_i) acc := acc - 1`.
3. A two-way conditional:
   - if `mode` is set, `res := acc + addend_i` (modulo 2^W);
   - otherwise, `res := acc XOR addend_i`.

Each data variable is held in a register with a write enable. A variable written by more than one construct gets one register. Its write ports are merged: the enables are ORed, and the data terms are each gated by their own enable before being ORed.

The environment sends one `start_i` pulse. It sends no other until `done_o` has pulsed. The data inputs are held steady while a run is in progress. Every control delay resets to 0. No control expression can be true while the token is absent, so the block stays idle until it gets a start pulse.

Named control cells and their token transitions:

| Cell | Enters on | Leaves as |
| --- | --- | --- |
| assign | `start_i` | `a1_done`, one cycle later |
| loop head | `a1_done` or `body_done` (call this `t`) | `t AND cond` goes to the body; `t AND NOT cond` is delayed one cycle and becomes `loop_done` |
| body | `t AND cond` | `body_done`, one cycle later |
| branch | `loop_done` | steered to THEN when `mode=1`, to ELSE when `mode=0`; the OR of the two is delayed one cycle and becomes `done_o` |

Top module: `pt_seq_ctrl`

## Requirements
- R1: After reset, `done_o`, `acc_o`, `res_o` and `mode_o` are all 0. With `start_i` low, `done_o` stays 0 and no register changes, whatever the data inputs do.
- R2: At the clock edge that samples `start_i` high, `acc_o` takes `seed_i` and `mode_o` takes `mode_i`. Both are visible in the cycle after the start cycle.
- R3: Each loop iteration takes exactly one cycle. While `acc > floor_i` (unsigned), `acc_o` decreases by 1 per cycle. It stops at `floor_i`.
- R4: When `seed_i <= floor_i`, the loop body never runs, and `acc_o` keeps the value `seed_i`.
- R5: At loop exit, with `mode_o=1`, `res_o` becomes `(acc + addend_i) mod 2^W`. With `mode_o=0`, `res_o` becomes `acc XOR addend_i`. `res_o` is visible in the same cycle as `done_o`.
- R6: `done_o` is a single-cycle pulse. It is high exactly n+3 cycles after the start cycle, where n = max(0, `seed_i` - `floor_i`). When it is high, no internal token is active.
- R7: A merged register never sees two write enables in the same cycle. It holds its value in every cycle without a write. So `res_o` does not change during the loop, and no output changes after `done_o` until the next start.
- R8: A new start pulse after `done_o` reruns the whole program with the current inputs.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle start token |
| seed_i | input | W | Value loaded into acc by the first assignment |
| floor_i | input | W | Lower bound for the loop's decrement |
| addend_i | input | W | Operand of the final conditional |
| mode_i | input | 1 | Branch selector, captured with the seed |
| done_o | output | 1 | One-cycle finish token |
| acc_o | output | W | Current value of acc |
| mode_o | output | 1 | Captured branch selector |
| res_o | output | W | Result register |

## Verification
The bench builds the block with W=6. At that width, a full-length loop of 63 iterations fits comfortably in the run, and an addition that wraps modulo 64 is easy to provoke. The bench covers these cases:
- zero-iteration loops, with seed below the floor and with seed equal to it;
- a single iteration;
- long loops;
- both branches of the conditional;
- back-to-back runs.

Every cycle, a behavioural model in the bench, stepping a small program counter, is compared with every output.

// File: rtl/pt_pkg.sv
package pt_pkg;
    typedef enum logic {
        BR_ELSE = 1'b0,
        BR_THEN = 1'b1
    } br_e;
endpackage

// File: rtl/pt_assign_cell.sv
module pt_assign_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic go_i,
    output logic wr_en_o,
    output logic done_o
);
    assign wr_en_o = go_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) done_o <= 1'b0;
        else        done_o <= go_i;
    end

    // R2: the finish token follows the start token by one cycle
    a_r2_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
        go_i |=> done_o);
endmodule

// File: rtl/pt_merge_reg.sv
module pt_merge_reg #(
    parameter int W = 8,
    parameter int N = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [N-1:0]   en_i,
    input  logic [N*W-1:0] dat_i,
    output logic [W-1:0]   q_o
);
    logic [N-1:0][W-1:0] gated;
    logic [W-1:0]        merged;
    logic                any_en;

    for (genvar g = 0; g < N; g++) begin : g_port
        assign gated[g] = dat_i[g*W +: W] & {W{en_i[g]}};
    end

    always_comb begin
        merged = '0;
        for (int k = 0; k < N; k++) merged = merged | gated[k];
    end

    assign any_en = |en_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      q_o <= '0;
        else if (any_en) q_o <= merged;
    end

    // R7: the constructs sharing this register never write it together
    a_r7_single_writer: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(en_i));
    // R7: without a write the register keeps its value
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !any_en |=> $stable(q_o));
endmodule

// File: rtl/pt_loop_ctl.sv
module pt_loop_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic go_i,
    input  logic body_done_i,
    input  logic cond_i,
    output logic body_go_o,
    output logic done_o
);
    logic tok;

    assign tok       = go_i | body_done_i;
    assign body_go_o = tok & cond_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) done_o <= 1'b0;
        else        done_o <= tok & ~cond_i;
    end

    // R3: a cycle that starts the body is never followed by the loop exit
    a_r3_no_exit_on_body: assert property (@(posedge clk) disable iff (!rst_n)
        body_go_o |=> !done_o);
    // R4: a token that finds the condition false leaves on the next cycle
    a_r4_exit_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (tok && !cond_i) |=> done_o);
endmodule

// File: rtl/pt_cond_ctl.sv
module pt_cond_ctl
    import pt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic go_i,
    input  logic sel_i,
    output logic then_go_o,
    output logic else_go_o,
    output logic done_o
);
    br_e br;

    assign br        = br_e'(sel_i);
    assign then_go_o = go_i & (br == BR_THEN);
    assign else_go_o = go_i & (br == BR_ELSE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) done_o <= 1'b0;
        else        done_o <= then_go_o | else_go_o;
    end

    // R5: whichever branch takes the token, the conditional finishes next cycle
    a_r5_branch_finishes: assert property (@(posedge clk) disable iff (!rst_n)
        (then_go_o || else_go_o) |=> done_o);
endmodule

// File: rtl/pt_seq_ctrl.sv
module pt_seq_ctrl #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic [W-1:0] seed_i,
    input  logic [W-1:0] floor_i,
    input  logic [W-1:0] addend_i,
    input  logic         mode_i,
    output logic         done_o,
    output logic [W-1:0] acc_o,
    output logic         mode_o,
    output logic [W-1:0] res_o
);
    localparam int ACC_PORTS = 2;
    localparam int RES_PORTS = 2;

    logic         a1_en, a1_done;
    logic         body_go, body_en, body_done;
    logic         loop_done, loop_cond;
    logic         then_go, else_go;
    logic [W-1:0] acc_q, res_q;
    logic         mode_q;

    // assignment: acc := seed, mode := mode_i
    pt_assign_cell u_a1 (
        .clk(clk), .rst_n(rst_n), .go_i(start_i),
        .wr_en_o(a1_en), .done_o(a1_done)
    );

    // loop: while (acc > floor) acc := acc - 1
    assign loop_cond = acc_q > floor_i;

    pt_loop_ctl u_loop (
        .clk(clk), .rst_n(rst_n), .go_i(a1_done), .body_done_i(body_done),
        .cond_i(loop_cond), .body_go_o(body_go), .done_o(loop_done)
    );

    pt_assign_cell u_body (
        .clk(clk), .rst_n(rst_n), .go_i(body_go),
        .wr_en_o(body_en), .done_o(body_done)
    );

    // conditional on the captured mode
    pt_cond_ctl u_cond (
        .clk(clk), .rst_n(rst_n), .go_i(loop_done), .sel_i(mode_q),
        .then_go_o(then_go), .else_go_o(else_go), .done_o(done_o)
    );

    // merged data registers
    pt_merge_reg #(.W(W), .N(ACC_PORTS)) u_acc (
        .clk(clk), .rst_n(rst_n),
        .en_i({body_en, a1_en}),
        .dat_i({acc_q - W'(1), seed_i}),
        .q_o(acc_q)
    );

    pt_merge_reg #(.W(1), .N(1)) u_mode (
        .clk(clk), .rst_n(rst_n),
        .en_i(a1_en), .dat_i(mode_i), .q_o(mode_q)
    );

    pt_merge_reg #(.W(W), .N(RES_PORTS)) u_res (
        .clk(clk), .rst_n(rst_n),
        .en_i({else_go, then_go}),
        .dat_i({acc_q ^ addend_i, acc_q + addend_i}),
        .q_o(res_q)
    );

    assign acc_o  = acc_q;
    assign mode_o = mode_q;
    assign res_o  = res_q;

    // R6: when the finish token appears, no internal token is left
    a_r6_quiet_at_finish: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !(a1_done || body_done || loop_done || body_go || then_go || else_go));
    // R6: the finish token lasts one cycle
    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R1: at most one control token exists at any time
    a_r1_one_token: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({a1_done, body_done, loop_done, done_o}));
endmodule

// File: tb/sim_pt_seq_ctrl.sv
module sim_pt_seq_ctrl;
    localparam int W    = 6;
    localparam int MASK = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic [W-1:0] seed_i = '0, floor_i = '0, addend_i = '0;
    logic         mode_i = 1'b0;
    logic         done_o, mode_o;
    logic [W-1:0] acc_o, res_o;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    bit live  = 1'b0;

    // reference model state
    int m_pc = 0;
    int m_acc = 0, m_res = 0, m_mode = 0;

    always #2 clk = ~clk;

    pt_seq_ctrl #(.W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .seed_i(seed_i), .floor_i(floor_i), .addend_i(addend_i), .mode_i(mode_i),
        .done_o(done_o), .acc_o(acc_o), .mode_o(mode_o), .res_o(res_o)
    );

    // behavioural program counter: 0 idle, 1 loop test, 2 branch, 3 finishing
    always @(posedge clk) begin
        if (!rst_n) begin
            m_pc = 0; m_acc = 0; m_res = 0; m_mode = 0;
        end else begin
            case (m_pc)
                0: if (start_i) begin
                       m_acc = int'(seed_i); m_mode = int'(mode_i); m_pc = 1;
                   end
                1: if (m_acc > int'(floor_i)) m_acc = m_acc - 1;
                   else m_pc = 2;
                2: begin
                       if (m_mode != 0) m_res = (m_acc + int'(addend_i)) & MASK;
                       else             m_res = m_acc ^ int'(addend_i);
                       m_pc = 3;
                   end
                default: m_pc = 0;
            endcase
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        cyc++;
        if (live) begin
            chk("R6 done", int'(done_o), (m_pc == 3) ? 1 : 0);
            chk("R3 acc",  int'(acc_o),  m_acc);
            chk("R2 mode", int'(mode_o), m_mode);
            chk("R5 res",  int'(res_o),  m_res);
        end
    end

    task automatic run(input int sd, input int fl, input int ad, input bit md);
        int lat;
        int n;
        int fin_acc;
        int fin_res;
        n       = (sd > fl) ? sd - fl : 0;
        fin_acc = (sd > fl) ? fl : sd;
        fin_res = md ? ((fin_acc + ad) & MASK) : (fin_acc ^ ad);
        seed_i = W'(sd); floor_i = W'(fl); addend_i = W'(ad); mode_i = md;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        lat = 1;
        chk("R2 seed loaded", int'(acc_o), sd);
        chk("R2 mode loaded", int'(mode_o), int'(md));
        while (!done_o && lat < 200) begin
            @(negedge clk);
            lat++;
        end
        chk("R6 latency", lat, n + 3);
        if (n == 0) chk("R4 acc kept", int'(acc_o), sd);
        else        chk("R3 acc final", int'(acc_o), fl);
        chk("R5 result", int'(res_o), fin_res);
        @(negedge clk);
        chk("R6 single pulse", int'(done_o), 0);
        repeat (3) @(negedge clk);
        chk("R7 res held", int'(res_o), fin_res);
        chk("R7 acc held", int'(acc_o), fin_acc);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset done", int'(done_o), 0);
        chk("R1 reset acc",  int'(acc_o), 0);
        chk("R1 reset res",  int'(res_o), 0);
        chk("R1 reset mode", int'(mode_o), 0);
        live = 1'b1;
        // R1: data inputs move with no start pulse
        for (int i = 0; i < 8; i++) begin
            seed_i = W'(i * 7); floor_i = W'(i); addend_i = W'(i * 3); mode_i = i[0];
            @(negedge clk);
            chk("R1 idle done", int'(done_o), 0);
            chk("R1 idle acc",  int'(acc_o), 0);
        end
        run(5, 2, 10, 1'b1);   // three iterations, add branch
        run(2, 7, 3, 1'b0);    // R4 seed below floor, xor branch
        run(9, 9, 21, 1'b1);   // R4 equal bound
        run(12, 11, 5, 1'b0);  // single iteration
        run(40, 30, 50, 1'b1); // R5 sum wraps modulo 64
        // R8: back-to-back reruns with fresh inputs
        run(63, 0, 1, 1'b1);
        run(0, 0, 63, 1'b0);
        run(33, 1, 17, 1'b0);
        live = 1'b0;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #40000;
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule